// File: doc/BRIEF.md
# Handshaked Chunk Transfer Controller

This block moves bytes over a byte-wide serial link in fixed-size chunks, with a short request/acknowledge exchange before each chunk. A static mode input picks one of two roles. As the sending end, it waits until its source FIFO holds data, then repeats a request byte on the link until the far end answers with an acknowledge byte. It then forwards one chunk of source bytes and goes back to requesting for the next chunk. As the receiving end, it hunts the incoming stream for a run of request bytes, answers once, and copies the chunk that follows into a sink FIFO. If the far end stops sending partway through, the chunk is filled out to its full length with all-ones bytes.

Line coding, serialisation and the FIFOs themselves sit outside the block. The link transmit side is a valid/ready byte port. The link receive side and the sink side are valid-only strobes. A built-in cycle meter reports, for each chunk, how many clock cycles passed between the start of the exchange and the first payload byte leaving the block.

Top module: `hsk_chunk_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `lnk_tx_valid`, `src_ready`, `snk_valid`, `tx_timeout` and `lat_valid` are all low.
- R2: In send mode (`mode_rx`=0), once the sender sees `src_valid` high while idle, every byte it puts on the link before the acknowledge is the request byte 0xAA.
- R3: After the acknowledge byte 0x10 arrives on `lnk_rx`, the sender forwards exactly CHUNK_LEN (default 1024) source bytes, in source order, one per accepted link handshake. It then returns to sending 0xAA, so a new exchange precedes every chunk.
- R4: The sender never takes a source byte (`src_valid` and `src_ready` both high) between the start of an exchange and the acknowledge of that exchange.
- R5: If no 0x10 arrives, the sender raises `tx_timeout` for one cycle and starts the exchange over. Pulses repeat every `ack_wait_limit`+2 cycles, and any received byte other than 0x10 does not count as an acknowledge.
- R6: In receive mode (`mode_rx`=1), a request is MIN_SYNC (default 2) consecutive 0xAA bytes. A shorter run, or 0xAA bytes broken up by other bytes, produces no acknowledge and no sink write.
- R7: For each recognised request, the receiver sends the byte 0x10 exactly once. It discards further 0xAA bytes and treats the first byte that is not 0xAA as the first payload byte.
- R8: Each chunk produces exactly CHUNK_LEN sink writes. Received bytes appear in arrival order, and any 0xAA inside the payload counts as data. The receiver then hunts for the next request.
- R9: If no link byte arrives for `idle_limit` cycles after the acknowledge, the receiver writes 0xFF bytes until the chunk reaches CHUNK_LEN. This also applies when no payload byte arrived at all.
- R10: `lat_valid` pulses once per chunk, and `lat_cycles` then gives the clock edges counted from the start edge to the edge of the first payload byte. In send mode, the start edge is the one where the idle sender sees `src_valid`, and the first payload byte is the first one accepted on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rx | input | 1 | 0 = sending end, 1 = receiving end; change only in reset |
| ack_wait_limit | input | TMO_W | Sender acknowledge wait, in cycles |
| idle_limit | input | TMO_W | Receiver link-silence limit, in cycles |
| src_data | input | 8 | Source FIFO head byte |
| src_valid | input | 1 | Source FIFO not empty |
| src_ready | output | 1 | Pop strobe to source FIFO |
| lnk_tx_data | output | 8 | Byte to link transmitter |
| lnk_tx_valid | output | 1 | Link transmit byte valid |
| lnk_tx_ready | input | 1 | Link transmitter accepts byte |
| lnk_rx_data | input | 8 | Byte from link receiver |
| lnk_rx_valid | input | 1 | Link receive byte strobe |
| snk_data | output | 8 | Byte written to sink FIFO |
| snk_valid | output | 1 | Sink write strobe |
| tx_timeout | output | 1 | One-cycle acknowledge-timeout pulse |
| lat_cycles | output | LAT_W | Measured chunk latency |
| lat_valid | output | 1 | Latency result strobe |

## Verification
The sending end is tried with a deep source and an always-ready link, which shows that payload order and chunk length are right. A second chunk under pseudo-random link back-pressure shows that bytes leave only on real handshakes. A run with no acknowledge plus a wrong answer byte isolates the timeout period from the acknowledge decode. On the receiving end, a clean request followed by a full chunk that contains 0xAA in its payload separates payload from sync. A stream cut short checks the fill-in. Broken request runs check that nothing reaches the sink without a proper request. A request followed by silence checks padding of an entirely empty chunk.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   typedef enum logic [1:0] {
      T_IDLE,
      T_SYNC,
      T_DATA
   } tx_st_e;

   typedef enum logic [2:0] {
      R_HUNT,
      R_ACK,
      R_SKIP,
      R_DATA,
      R_PAD
   } rx_st_e;

endpackage

// File: rtl/hsk_tx_fsm.sv
module hsk_tx_fsm
   import hsk_pkg::*;
#(
   parameter int          CHUNK_LEN = 1024,
   parameter int          TMO_W     = 16,
   parameter logic [7:0]  SYNC_BYTE = 8'hAA,
   parameter logic [7:0]  ACK_BYTE  = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMO_W-1:0] ack_wait_limit,
   input  logic [7:0]       src_data,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [7:0]       rx_data,
   input  logic             rx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic             timeout,
   output logic             lat_start,
   output logic             lat_stop
);

   localparam int CW = $clog2(CHUNK_LEN);
   localparam logic [CW-1:0] LAST_BEAT = CW'(CHUNK_LEN - 1);

   tx_st_e           state;
   logic [CW-1:0]    beat_cnt;
   logic [TMO_W-1:0] wait_tmr;
   logic             beat_hs;
   logic             ack_hit;

   assign ack_hit = rx_valid && (rx_data == ACK_BYTE);
   assign beat_hs = (state == T_DATA) && src_valid && tx_ready;

   always_comb begin
      tx_valid  = 1'b0;
      tx_data   = SYNC_BYTE;
      src_ready = 1'b0;
      case (state)
         T_SYNC: tx_valid = 1'b1;
         T_DATA: begin
            tx_valid  = src_valid;
            tx_data   = src_data;
            src_ready = tx_ready;
         end
         default: ;
      endcase
   end

   assign lat_start = en && (state == T_IDLE) && src_valid;
   assign lat_stop  = beat_hs && (beat_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         state    <= T_IDLE;
         beat_cnt <= '0;
         wait_tmr <= '0;
         timeout  <= 1'b0;
      end else begin
         timeout <= 1'b0;
         case (state)
            T_IDLE: begin
               if (src_valid) begin
                  state    <= T_SYNC;
                  wait_tmr <= '0;
               end
            end
            T_SYNC: begin
               if (ack_hit) begin
                  state    <= T_DATA;
                  beat_cnt <= '0;
               end else if (wait_tmr == ack_wait_limit) begin
                  timeout <= 1'b1;
                  state   <= T_IDLE;
               end else begin
                  wait_tmr <= wait_tmr + 1'b1;
               end
            end
            T_DATA: begin
               if (beat_hs) begin
                  if (beat_cnt == LAST_BEAT) begin
                     state    <= T_IDLE;
                     beat_cnt <= '0;
                  end else begin
                     beat_cnt <= beat_cnt + 1'b1;
                  end
               end
            end
            default: state <= T_IDLE;
         endcase
      end
   end

   AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);                                           // R5
   AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (state == T_IDLE));                                  // R5
   AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ready && ($past(state) == T_SYNC)) |-> $past(ack_hit));     // R4
   AST_CHUNK_END: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_hs && (beat_cnt == LAST_BEAT)) |=> (state == T_IDLE));     // R3

endmodule

// File: rtl/hsk_rx_fsm.sv
module hsk_rx_fsm
   import hsk_pkg::*;
#(
   parameter int          CHUNK_LEN = 1024,
   parameter int          TMO_W     = 16,
   parameter int          MIN_SYNC  = 2,
   parameter logic [7:0]  SYNC_BYTE = 8'hAA,
   parameter logic [7:0]  ACK_BYTE  = 8'h10,
   parameter logic [7:0]  PAD_BYTE  = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMO_W-1:0] idle_limit,
   input  logic [7:0]       rx_data,
   input  logic             rx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [7:0]       snk_data,
   output logic             snk_valid,
   output logic             lat_start,
   output logic             lat_stop
);

   localparam int CW = $clog2(CHUNK_LEN);
   localparam int SW = $clog2(MIN_SYNC + 1);
   localparam logic [CW-1:0] LAST_BEAT = CW'(CHUNK_LEN - 1);
   localparam logic [SW-1:0] SYNC_LAST = SW'(MIN_SYNC - 1);

   rx_st_e           state;
   logic [CW-1:0]    beat_cnt;
   logic [SW-1:0]    sync_run;
   logic [TMO_W-1:0] idle_tmr;
   logic             is_sync;
   logic             idle_hit;
   logic             first_pay;

   assign is_sync   = (rx_data == SYNC_BYTE);
   assign idle_hit  = !rx_valid && (idle_tmr == idle_limit);
   assign first_pay = (state == R_SKIP) && rx_valid && !is_sync;

   assign tx_valid  = (state == R_ACK);
   assign tx_data   = ACK_BYTE;

   assign lat_start = en && (state == R_HUNT) && rx_valid && is_sync &&
                      (sync_run == SYNC_LAST);
   assign lat_stop  = first_pay || ((state == R_PAD) && (beat_cnt == '0));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         state     <= R_HUNT;
         beat_cnt  <= '0;
         sync_run  <= '0;
         idle_tmr  <= '0;
         snk_valid <= 1'b0;
         snk_data  <= '0;
      end else begin
         snk_valid <= 1'b0;
         case (state)
            R_HUNT: begin
               if (rx_valid) begin
                  if (!is_sync) begin
                     sync_run <= '0;
                  end else if (sync_run == SYNC_LAST) begin
                     sync_run <= '0;
                     state    <= R_ACK;
                  end else begin
                     sync_run <= sync_run + 1'b1;
                  end
               end
            end
            R_ACK: begin
               if (tx_ready) begin
                  state    <= R_SKIP;
                  idle_tmr <= '0;
               end
            end
            R_SKIP: begin
               if (first_pay) begin
                  snk_valid <= 1'b1;
                  snk_data  <= rx_data;
                  beat_cnt  <= CW'(1);
                  idle_tmr  <= '0;
                  state     <= R_DATA;
               end else if (rx_valid) begin
                  idle_tmr <= '0;
               end else if (idle_hit) begin
                  beat_cnt <= '0;
                  state    <= R_PAD;
               end else begin
                  idle_tmr <= idle_tmr + 1'b1;
               end
            end
            R_DATA: begin
               if (rx_valid) begin
                  snk_valid <= 1'b1;
                  snk_data  <= rx_data;
                  idle_tmr  <= '0;
                  if (beat_cnt == LAST_BEAT) begin
                     beat_cnt <= '0;
                     state    <= R_HUNT;
                  end else begin
                     beat_cnt <= beat_cnt + 1'b1;
                  end
               end else if (idle_hit) begin
                  state <= R_PAD;
               end else begin
                  idle_tmr <= idle_tmr + 1'b1;
               end
            end
            R_PAD: begin
               snk_valid <= 1'b1;
               snk_data  <= PAD_BYTE;
               if (beat_cnt == LAST_BEAT) begin
                  beat_cnt <= '0;
                  state    <= R_HUNT;
               end else begin
                  beat_cnt <= beat_cnt + 1'b1;
               end
            end
            default: state <= R_HUNT;
         endcase
      end
   end

   AST_PAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == R_PAD) |=> (snk_valid && (snk_data == PAD_BYTE)));     // R9
   AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == R_HUNT) |=> !snk_valid);                               // R6
   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));     // R7
   AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_valid);                           // R7

endmodule

// File: rtl/hsk_lat_meter.sv
module hsk_lat_meter #(
   parameter int LAT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   output logic [LAT_W-1:0] lat_cycles,
   output logic             lat_valid
);

   logic [LAT_W-1:0] run_cnt;
   logic             running;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt    <= '0;
         running    <= 1'b0;
         lat_cycles <= '0;
         lat_valid  <= 1'b0;
      end else begin
         lat_valid <= 1'b0;
         if (start) begin
            running <= 1'b1;
            run_cnt <= LAT_W'(1);
         end else if (running) begin
            if (stop) begin
               lat_cycles <= run_cnt;
               lat_valid  <= 1'b1;
               running    <= 1'b0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   end

   AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid |-> (lat_cycles != '0));                               // R10
   AST_LAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid |=> !lat_valid);                                       // R10

endmodule

// File: rtl/hsk_chunk_ctrl.sv
module hsk_chunk_ctrl #(
   parameter int          CHUNK_LEN = 1024,
   parameter int          MIN_SYNC  = 2,
   parameter logic [7:0]  SYNC_BYTE = 8'hAA,
   parameter logic [7:0]  ACK_BYTE  = 8'h10,
   parameter logic [7:0]  PAD_BYTE  = 8'hFF,
   parameter int          TMO_W     = 16,
   parameter int          LAT_W     = 32,
   parameter bit          LAT_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_rx,
   input  logic [TMO_W-1:0] ack_wait_limit,
   input  logic [TMO_W-1:0] idle_limit,
   input  logic [7:0]       src_data,
   input  logic             src_valid,
   output logic             src_ready,
   output logic [7:0]       lnk_tx_data,
   output logic             lnk_tx_valid,
   input  logic             lnk_tx_ready,
   input  logic [7:0]       lnk_rx_data,
   input  logic             lnk_rx_valid,
   output logic [7:0]       snk_data,
   output logic             snk_valid,
   output logic             tx_timeout,
   output logic [LAT_W-1:0] lat_cycles,
   output logic             lat_valid
);

   if (CHUNK_LEN < 2) begin : g_chk_chunk
      $error("CHUNK_LEN must be at least 2");
   end
   if (MIN_SYNC < 1) begin : g_chk_sync
      $error("MIN_SYNC must be at least 1");
   end
   if (SYNC_BYTE == ACK_BYTE) begin : g_chk_codes
      $error("request and acknowledge bytes must differ");
   end
   if (TMO_W < 2 || LAT_W < 2) begin : g_chk_widths
      $error("counter widths too small");
   end

   logic       t_src_ready, t_valid, t_lat_start, t_lat_stop;
   logic [7:0] t_data;
   logic       r_valid, r_lat_start, r_lat_stop;
   logic [7:0] r_data;
   logic       m_start, m_stop;

   hsk_tx_fsm #(
      .CHUNK_LEN (CHUNK_LEN),
      .TMO_W     (TMO_W),
      .SYNC_BYTE (SYNC_BYTE),
      .ACK_BYTE  (ACK_BYTE)
   ) u_tx (
      .clk            (clk),
      .rst_n          (rst_n),
      .en             (!mode_rx),
      .ack_wait_limit (ack_wait_limit),
      .src_data       (src_data),
      .src_valid      (src_valid),
      .src_ready      (t_src_ready),
      .rx_data        (lnk_rx_data),
      .rx_valid       (lnk_rx_valid),
      .tx_data        (t_data),
      .tx_valid       (t_valid),
      .tx_ready       (lnk_tx_ready),
      .timeout        (tx_timeout),
      .lat_start      (t_lat_start),
      .lat_stop       (t_lat_stop)
   );

   hsk_rx_fsm #(
      .CHUNK_LEN (CHUNK_LEN),
      .TMO_W     (TMO_W),
      .MIN_SYNC  (MIN_SYNC),
      .SYNC_BYTE (SYNC_BYTE),
      .ACK_BYTE  (ACK_BYTE),
      .PAD_BYTE  (PAD_BYTE)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (mode_rx),
      .idle_limit (idle_limit),
      .rx_data    (lnk_rx_data),
      .rx_valid   (lnk_rx_valid),
      .tx_data    (r_data),
      .tx_valid   (r_valid),
      .tx_ready   (lnk_tx_ready),
      .snk_data   (snk_data),
      .snk_valid  (snk_valid),
      .lat_start  (r_lat_start),
      .lat_stop   (r_lat_stop)
   );

   assign src_ready    = !mode_rx && t_src_ready;
   assign lnk_tx_valid = mode_rx ? r_valid : t_valid;
   assign lnk_tx_data  = mode_rx ? r_data  : t_data;
   assign m_start      = mode_rx ? r_lat_start : t_lat_start;
   assign m_stop       = mode_rx ? r_lat_stop  : t_lat_stop;

   if (LAT_EN) begin : g_lat
      hsk_lat_meter #(.LAT_W(LAT_W)) u_lat (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (m_start),
         .stop       (m_stop),
         .lat_cycles (lat_cycles),
         .lat_valid  (lat_valid)
      );
   end else begin : g_no_lat
      assign lat_cycles = '0;
      assign lat_valid  = 1'b0;
   end

   AST_RX_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      mode_rx |-> !src_ready);                                         // R4
   AST_TX_NO_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_rx |-> !snk_valid);                                        // R8

endmodule

// File: tb/tb_hsk_chunk_ctrl.sv
module tb_hsk_chunk_ctrl;

   localparam int CL = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_rx = 1'b0;
   logic [15:0] ack_wait_limit = 16'd200;
   logic [15:0] idle_limit = 16'd30;
   logic [7:0]  src_data = '0;
   logic        src_valid = 1'b0;
   logic        src_ready;
   logic [7:0]  lnk_tx_data;
   logic        lnk_tx_valid;
   logic        lnk_tx_ready = 1'b1;
   logic [7:0]  lnk_rx_data = '0;
   logic        lnk_rx_valid = 1'b0;
   logic [7:0]  snk_data;
   logic        snk_valid;
   logic        tx_timeout;
   logic [31:0] lat_cycles;
   logic        lat_valid;

   always #4 clk = ~clk;

   hsk_chunk_ctrl dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_rx        (mode_rx),
      .ack_wait_limit (ack_wait_limit),
      .idle_limit     (idle_limit),
      .src_data       (src_data),
      .src_valid      (src_valid),
      .src_ready      (src_ready),
      .lnk_tx_data    (lnk_tx_data),
      .lnk_tx_valid   (lnk_tx_valid),
      .lnk_tx_ready   (lnk_tx_ready),
      .lnk_rx_data    (lnk_rx_data),
      .lnk_rx_valid   (lnk_rx_valid),
      .snk_data       (snk_data),
      .snk_valid      (snk_valid),
      .tx_timeout     (tx_timeout),
      .lat_cycles     (lat_cycles),
      .lat_valid      (lat_valid)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // scoreboard state
   logic [7:0] src_q[$];
   logic [7:0] ltx_exp_q[$];
   logic [7:0] snk_exp_q[$];
   string      rx_tag = "R8";
   bit         src_en = 1'b0;
   bit         src_hs = 1'b0;
   bit         tx_acked = 1'b0;
   int         sync_seen = 0;
   int         pay_in_chunk = 0;
   int         chunks_done = 0;
   int         early_pop = 0;
   int         acks_sent = 0;
   int         snk_count = 0;
   int         tmo_n = 0;
   longint     tmo_e[4];
   longint     ecnt = 0;
   bit         lat_arm = 1'b0;
   bit         lat_wait_stop = 1'b0;
   bit         lat_got = 1'b0;
   longint     lat_start_e = 0;
   longint     lat_stop_e = 0;
   longint     lat_seen = 0;
   bit         stall_en = 1'b0;
   logic [7:0] lf = 8'h5A;

   always @(posedge clk) ecnt <= ecnt + 1;

   // source FIFO model
   always begin
      @(posedge clk);
      #2;
      if (src_hs && src_q.size() != 0) void'(src_q.pop_front());
      src_valid = src_en && (src_q.size() != 0);
      src_data  = (src_q.size() != 0) ? src_q[0] : 8'h00;
   end

   // back-pressure pattern on the link transmitter
   always begin
      @(posedge clk);
      #3;
      if (stall_en) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         lnk_tx_ready = lf[0] | lf[2];
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         src_hs = src_valid && src_ready;
         if (lat_arm && src_valid) begin
            lat_start_e = ecnt + 1;
            lat_arm = 1'b0;
            lat_wait_stop = 1'b1;
         end
         if (!mode_rx) begin
            if (src_hs && !tx_acked) early_pop++;
            if (lnk_tx_valid && lnk_tx_ready) begin
               if (!tx_acked) begin
                  check(lnk_tx_data == 8'hAA, "R2", "request byte", lnk_tx_data, 8'hAA);
                  sync_seen++;
               end else if (ltx_exp_q.size() == 0) begin
                  check(1'b0, "R3", "payload byte with nothing queued", lnk_tx_data, -1);
               end else begin
                  check(lnk_tx_data == ltx_exp_q[0], "R3", "payload byte",
                        lnk_tx_data, ltx_exp_q[0]);
                  void'(ltx_exp_q.pop_front());
                  if (lat_wait_stop) begin
                     lat_stop_e = ecnt + 1;
                     lat_wait_stop = 1'b0;
                  end
                  pay_in_chunk++;
                  if (pay_in_chunk == CL) begin
                     tx_acked = 1'b0;
                     sync_seen = 0;
                     pay_in_chunk = 0;
                     chunks_done++;
                  end
               end
            end
            if (lnk_rx_valid && lnk_rx_data == 8'h10) tx_acked = 1'b1;
            if (tx_timeout && tmo_n < 4) begin
               tmo_e[tmo_n] = ecnt;
               tmo_n++;
            end
         end else begin
            if (lnk_tx_valid && lnk_tx_ready) begin
               check(lnk_tx_data == 8'h10, "R7", "acknowledge byte", lnk_tx_data, 8'h10);
               acks_sent++;
            end
         end
         if (snk_valid) begin
            snk_count++;
            if (snk_exp_q.size() == 0) begin
               check(1'b0, rx_tag, "unexpected sink write", snk_data, -1);
            end else begin
               check(snk_data == snk_exp_q[0], rx_tag, "sink byte", snk_data, snk_exp_q[0]);
               void'(snk_exp_q.pop_front());
            end
         end
         if (lat_valid && !lat_got) begin
            lat_seen = lat_cycles;
            lat_got = 1'b1;
         end
      end
   end

   task automatic do_reset(input bit rxm);
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      mode_rx = rxm;
      src_en = 1'b0;
      src_q.delete();
      ltx_exp_q.delete();
      snk_exp_q.delete();
      lnk_rx_valid = 1'b0;
      stall_en = 1'b0;
      lnk_tx_ready = 1'b1;
      tx_acked = 1'b0;
      sync_seen = 0;
      pay_in_chunk = 0;
      chunks_done = 0;
      early_pop = 0;
      tmo_n = 0;
      lat_got = 1'b0;
      lat_arm = 1'b0;
      lat_wait_stop = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic drive(input logic [7:0] b);
      @(posedge clk);
      #1;
      lnk_rx_valid = 1'b1;
      lnk_rx_data  = b;
   endtask

   task automatic quiet(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
         lnk_rx_valid = 1'b0;
      end
   endtask

   task automatic send_ack(input logic [7:0] b);
      drive(b);
      quiet(1);
   endtask

   task automatic wait_q_empty(input int limit);
      for (int i = 0; i < limit; i++) begin
         if (snk_exp_q.size() == 0) break;
         @(posedge clk);
      end
   endtask

   initial begin
      // ---------------- reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(lnk_tx_valid == 1'b0, "R1", "lnk_tx_valid in reset", lnk_tx_valid, 0);
      check(src_ready == 1'b0, "R1", "src_ready in reset", src_ready, 0);
      check(snk_valid == 1'b0, "R1", "snk_valid in reset", snk_valid, 0);
      check(tx_timeout == 1'b0, "R1", "tx_timeout in reset", tx_timeout, 0);
      check(lat_valid == 1'b0, "R1", "lat_valid in reset", lat_valid, 0);
      do_reset(1'b0);
      @(negedge clk);
      check(lnk_tx_valid == 1'b0, "R1", "lnk_tx_valid after reset", lnk_tx_valid, 0);
      check(src_ready == 1'b0, "R1", "src_ready after reset", src_ready, 0);

      // ---------------- sender: two chunks
      @(posedge clk);
      #1;
      for (int i = 0; i < 1500; i++) begin
         src_q.push_back(8'((i * 37 + 5) & 255));
         ltx_exp_q.push_back(8'((i * 37 + 5) & 255));
      end
      lat_arm = 1'b1;
      src_en = 1'b1;
      wait (sync_seen >= 3);
      send_ack(8'h10);
      wait (chunks_done == 1 || done);
      check(early_pop == 0, "R4", "source pops before ack, chunk 1", early_pop, 0);
      wait (lat_got || done);
      check(lat_seen == lat_stop_e - lat_start_e, "R10", "latency cycles",
            lat_seen, lat_stop_e - lat_start_e);
      // second chunk under back-pressure; first bytes must be requests again
      stall_en = 1'b1;
      wait (sync_seen >= 3);
      check(pay_in_chunk == 0, "R3", "no payload before second exchange", pay_in_chunk, 0);
      send_ack(8'h10);
      for (int i = 0; i < 20000; i++) begin
         if (ltx_exp_q.size() == 0) break;
         @(posedge clk);
      end
      check(ltx_exp_q.size() == 0, "R3", "bytes left unsent", ltx_exp_q.size(), 0);
      check(early_pop == 0, "R4", "source pops before ack, chunk 2", early_pop, 0);
      repeat (20) @(posedge clk);

      // ---------------- sender: acknowledge timeout
      do_reset(1'b0);
      ack_wait_limit = 16'd20;
      for (int i = 0; i < 5; i++) src_q.push_back(8'(i + 1));
      src_en = 1'b1;
      wait (tmo_n >= 1 || done);
      send_ack(8'h11);
      wait (tmo_n >= 3 || done);
      check(tmo_e[1] - tmo_e[0] == 22, "R5", "timeout period 1", tmo_e[1] - tmo_e[0], 22);
      check(tmo_e[2] - tmo_e[1] == 22, "R5", "timeout period 2", tmo_e[2] - tmo_e[1], 22);
      check(early_pop == 0, "R4", "source pops without ack", early_pop, 0);
      check(src_q.size() == 5, "R4", "source depth without ack", src_q.size(), 5);

      // ---------------- receiver: full chunk
      do_reset(1'b1);
      idle_limit = 16'd30;
      acks_sent = 0;
      snk_count = 0;
      rx_tag = "R8";
      for (int i = 0; i < CL; i++) snk_exp_q.push_back(8'((i * 11 + 33) & 255));
      drive(8'hAA);
      drive(8'hAA);
      drive(8'hAA);
      quiet(4);
      check(acks_sent == 1, "R7", "acks after request", acks_sent, 1);
      check(snk_count == 0, "R7", "sink writes before payload", snk_count, 0);
      for (int i = 0; i < CL; i++) drive(8'((i * 11 + 33) & 255));
      quiet(3);
      wait_q_empty(100);
      check(snk_exp_q.size() == 0, "R8", "bytes missing from sink", snk_exp_q.size(), 0);
      check(snk_count == CL, "R8", "sink writes per chunk", snk_count, CL);
      check(acks_sent == 1, "R7", "acks after chunk", acks_sent, 1);

      // ---------------- receiver: short chunk padded
      rx_tag = "R9";
      snk_count = 0;
      for (int i = 0; i < 10; i++) snk_exp_q.push_back(8'(8'h40 + i));
      for (int i = 10; i < CL; i++) snk_exp_q.push_back(8'hFF);
      drive(8'hAA);
      drive(8'hAA);
      quiet(5);
      for (int i = 0; i < 10; i++) drive(8'(8'h40 + i));
      quiet(40);
      wait_q_empty(3000);
      quiet(10);
      check(snk_exp_q.size() == 0, "R9", "pad bytes missing", snk_exp_q.size(), 0);
      check(snk_count == CL, "R9", "sink writes for short chunk", snk_count, CL);
      check(acks_sent == 2, "R7", "acks after second request", acks_sent, 2);

      // ---------------- receiver: broken requests
      snk_count = 0;
      rx_tag = "R6";
      drive(8'hAA);
      drive(8'h55);
      drive(8'hAA);
      drive(8'h33);
      drive(8'h44);
      quiet(5);
      drive(8'hAA);
      quiet(3);
      drive(8'h01);
      drive(8'h02);
      quiet(60);
      check(acks_sent == 2, "R6", "acks for broken request", acks_sent, 2);
      check(snk_count == 0, "R6", "sink writes for broken request", snk_count, 0);

      // ---------------- receiver: request then silence
      rx_tag = "R9";
      for (int i = 0; i < CL; i++) snk_exp_q.push_back(8'hFF);
      drive(8'hAA);
      drive(8'hAA);
      quiet(2);
      wait_q_empty(3000);
      quiet(10);
      check(snk_exp_q.size() == 0, "R9", "empty chunk pad missing", snk_exp_q.size(), 0);
      check(snk_count == CL, "R9", "writes for empty chunk", snk_count, CL);
      check(acks_sent == 3, "R7", "acks after third request", acks_sent, 3);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
   end

endmodule